// File: doc/BRIEF.md
# Two-Stage Serial Bit Rate Generator

This block turns the system clock into a serial bit clock for a shift engine. It uses two divide stages in series. The first stage is an even prescaler. The second stage divides by one plus an 8-bit rate value. The serial clock frequency is the system clock divided by (prescale × (1 + rate)). The output has a 50 percent duty cycle.

Each time the serial clock changes level, a one-cycle strobe marks the change. One strobe marks rising changes and the other marks falling changes, so the shift engine never has to detect edges itself. While the enable input is low, every counter is held at zero and the serial clock rests low. When enable goes high, counting starts again from a known phase.

A new prescale or rate value is taken up only when a serial period ends. A period ends on the falling change, or whenever the block is idle. Because of this, a reconfiguration never cuts a half-period short or stretches it.

Top module: `serial_rate_gen`

## Requirements
- R1: During reset, and in the first cycle after reset, `sclk`, `rise_stb` and `fall_stb` are all 0.
- R2: While `en` is low, `sclk`, `rise_stb` and `fall_stb` read 0 one cycle later. After `en` is set high, the first rising change of `sclk` comes exactly one half-period later, counted in system clock edges.
- R3: Each high half and each low half of `sclk` lasts exactly (P/2) × (1 + rate) system clock cycles. P is the effective prescale.
- R4: The effective prescale ignores bit 0 of `presc`. An odd setting behaves like the even value just below it; for example, 5 behaves as 4.
- R5: A `presc` setting of 0 or 1 is treated as a prescale of 2.
- R6: The rate field covers the full range 0 to 255. A rate of 255 with a prescale of 254 gives half-periods of 32512 cycles.
- R7: The smallest total divide is 2. With a prescale of 2 and a rate of 0, `sclk` changes level on every system clock cycle.
- R8: `rise_stb` is high for exactly the one cycle in which `sclk` first reads 1 after reading 0. `fall_stb` is high for exactly the one cycle in which `sclk` first reads 0 after reading 1. The two strobes are never high together.
- R9: Changes to `presc` or `rate` while `en` is high take effect only from the falling change of `sclk` that ends the current period. The half-period in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low holds the generator idle |
| presc | input | 8 | First-stage prescale setting (even, 2 to 254) |
| rate | input | 8 | Second-stage rate field; divide is 1 + rate |
| sclk | output | 1 | Serial clock, 50 percent duty, idle low |
| rise_stb | output | 1 | One-cycle strobe in the cycle `sclk` goes high |
| fall_stb | output | 1 | One-cycle strobe in the cycle `sclk` goes low |

## Verification
Directed settings cover the extremes: the smallest divide, the largest divide, prescale values of 0, 1 and odd numbers, and a rate at its maximum. These cases separate a correct half-period formula from off-by-one counting, from handling of the prescale low bit, and from clamping of small prescale values. Constrained random prescale and rate pairs then measure several consecutive half-periods against the formula. This shows whether both stages scale correctly together, rather than only at the chosen corners. A reconfiguration made partway through a high half shows whether new values wait for the end of the period. An enable drop made partway through a period shows whether the output returns to idle and restarts from a clean phase.

// File: rtl/srg_pkg.sv
// Shared defaults for the serial rate generator.
// Assumes: both configuration fields are plain unsigned binary values.
package srg_pkg;
    parameter int SRG_PRESC_W = 8;
    parameter int SRG_RATE_W  = 8;
endpackage

// File: rtl/srg_cfg_hold.sv
// Configuration holder. It cleans up the prescale setting: bit 0 is dropped
// and a result below 2 is raised to 2. It then stores the half prescale and
// the rate. New values are loaded only when 'load' is high, which happens
// while idle or at the end of a serial period.
// Assumes: the load request is generated in the cycle the period ends.
module srg_cfg_hold #(
    parameter int PW = srg_pkg::SRG_PRESC_W,
    parameter int RW = srg_pkg::SRG_RATE_W,
    localparam int HW = PW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] presc_in,
    input  logic [RW-1:0] rate_in,
    output logic [HW-1:0] half_q,
    output logic [RW-1:0] rate_q
);
    logic [HW-1:0] half_d;

    // Half of the even prescale; a setting of 0 or 1 becomes a half of 1.
    always_comb begin
        half_d = presc_in[PW-1:1];
        if (half_d == '0) half_d = HW'(1);
    end

    // Keep the active settings; replace them only when a load is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= HW'(1);
            rate_q <= '0;
        end else if (load) begin
            half_q <= half_d;
            rate_q <= rate_in;
        end
    end

    // R5: the stored half prescale is never zero.
    always_ff @(posedge clk) begin
        if (rst_n) assert_half_nonzero_R5: assert (half_q != '0);
    end
endmodule

// File: rtl/srg_prescaler.sv
// First divide stage. It issues a one-cycle tick once every 'half'
// system cycles while enabled. The count is held at zero while disabled.
// Assumes: half is at least 1.
module srg_prescaler #(
    parameter int HW = srg_pkg::SRG_PRESC_W - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [HW-1:0] half,
    output logic          tick
);
    logic [HW-1:0] cnt_q;

    // A tick fires on the last count of each half-prescale window.
    always_comb tick = en && (cnt_q == half - HW'(1));

    // Step the count, wrapping after a tick and clearing while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) cnt_q <= '0;
        else                       cnt_q <= cnt_q + HW'(1);
    end

    // R3: the count restarts at zero after every tick.
    assert_tick_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt_q == '0);
endmodule

// File: rtl/srg_rate_stage.sv
// Second divide stage. It counts 1 + rate prescaler ticks for each half
// period, then toggles the serial clock. In the same cycle it raises the
// rising or the falling strobe. While disabled, everything is held low.
// Assumes: ticks arrive only while enabled.
module srg_rate_stage #(
    parameter int RW = srg_pkg::SRG_RATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [RW-1:0] rate,
    output logic          end_of_period,
    output logic          sclk_q,
    output logic          rise_q,
    output logic          fall_q
);
    logic [RW-1:0] rcnt_q;
    logic          toggle;

    // A half period is complete when the last of the 1 + rate ticks arrives.
    always_comb begin
        toggle        = tick && (rcnt_q == rate);
        end_of_period = toggle && sclk_q;
    end

    // Count ticks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || toggle) rcnt_q <= '0;
        else if (tick)               rcnt_q <= rcnt_q + RW'(1);
    end

    // Drive the serial clock and its one-cycle level-change strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sclk_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= toggle && !sclk_q;
            fall_q <= toggle && sclk_q;
            if (toggle) sclk_q <= !sclk_q;
        end
    end

    // R8: the two strobes are never high together.
    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_q && fall_q));
    // R8: a rising strobe coincides with a low-to-high change of sclk.
    assert_rise_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> (sclk_q && !$past(sclk_q)));
    // R8: a falling strobe coincides with a high-to-low change of sclk.
    assert_fall_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_q |-> (!sclk_q && $past(sclk_q)));
    // R2: one cycle after enable is low, the outputs are idle.
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!sclk_q && !rise_q && !fall_q));
endmodule

// File: rtl/serial_rate_gen.sv
// Top level of the two-stage serial bit rate generator.
// Output frequency = clk / (P * (1 + rate)), where P is the even prescale.
// Each half of the serial clock lasts (P/2) * (1 + rate) cycles.
// Assumes: presc and rate are quasi-static and may change at any time;
// a change is taken up only while idle or at the end of a period.
module serial_rate_gen #(
    parameter int PW = srg_pkg::SRG_PRESC_W,
    parameter int RW = srg_pkg::SRG_RATE_W,
    localparam int HW = PW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] presc,
    input  logic [RW-1:0] rate,
    output logic          sclk,
    output logic          rise_stb,
    output logic          fall_stb
);
    logic [HW-1:0] half_q;
    logic [RW-1:0] rate_q;
    logic          tick;
    logic          end_of_period;
    logic          cfg_load;

    // Load new settings while idle or when a period finishes.
    always_comb cfg_load = !en || end_of_period;

    srg_cfg_hold #(.PW(PW), .RW(RW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .presc_in(presc), .rate_in(rate),
        .half_q(half_q), .rate_q(rate_q)
    );

    srg_prescaler #(.HW(HW)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(en), .half(half_q), .tick(tick)
    );

    srg_rate_stage #(.RW(RW)) u_rate (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .rate(rate_q),
        .end_of_period(end_of_period),
        .sclk_q(sclk), .rise_q(rise_stb), .fall_q(fall_stb)
    );

    // R9: while running, the active settings change only at a falling strobe.
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !fall_stb) |-> ($stable(half_q) && $stable(rate_q)));
endmodule

// File: tb/serial_rate_gen_tb.sv
// Self-checking bench: directed corner cases plus constrained random settings.
module serial_rate_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 70000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] presc = 8'd2;
    logic [7:0] rate = 8'd0;
    logic       sclk, rise_stb, fall_stb;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    serial_rate_gen u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .presc(presc), .rate(rate),
        .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected half-period length from the requirements.
    function automatic int exp_half(input int p, input int r);
        int pp;
        pp = p & 32'hFE;
        if (pp < 2) pp = 2;
        return (pp / 2) * (r + 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Count negedges until sclk reaches lvl. Also checks that strobes appear
    // only at the change (R8).
    task automatic wait_level(input logic lvl, output int n);
        int stray;
        n = 0;
        stray = 0;
        do begin
            @(negedge clk);
            n++;
            if (sclk != lvl && (rise_stb || fall_stb)) stray++;
        end while (sclk != lvl && n < LIMIT);
        check(stray == 0, "R8 no stray strobe", stray, 0);
        if (lvl) check(rise_stb && !fall_stb, "R8 rise strobe", rise_stb, 1);
        else     check(fall_stb && !rise_stb, "R8 fall strobe", fall_stb, 1);
    endtask

    // Start from idle with settings p/r; measure the first rise and then
    // 'halves' more half-periods.
    task automatic run_cfg(input int p, input int r, input int halves, input string tag);
        int n;
        int e;
        @(negedge clk);
        en = 1'b0;
        presc = p[7:0];
        rate = r[7:0];
        @(negedge clk);
        en = 1'b1;
        e = exp_half(p, r);
        wait_level(1'b1, n);
        check(n == e, {tag, " first rise (R2)"}, n, e);
        for (int i = 0; i < halves; i++) begin
            wait_level(i % 2 == 0 ? 1'b0 : 1'b1, n);
            check(n == e, {tag, " half period (R3)"}, n, e);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected < %0d", cycles, 190000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: outputs low during reset
        check(!sclk && !rise_stb && !fall_stb, "R1 in reset", sclk, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sclk && !rise_stb && !fall_stb, "R1 after reset", sclk, 0);

        // R7: minimum total divide, toggles every cycle
        run_cfg(2, 0, 4, "R7 min divide");
        // R5: prescale 0 and 1 treated as 2
        run_cfg(0, 3, 2, "R5 presc 0");
        run_cfg(1, 2, 2, "R5 presc 1");
        // R4: odd prescale drops its low bit
        run_cfg(5, 1, 3, "R4 presc 5");
        run_cfg(11, 0, 2, "R4 presc 11");
        // R3: general cases
        run_cfg(6, 4, 3, "R3 p6 r4");
        run_cfg(254, 0, 2, "R3 p254 r0");
        // R6: full range of the rate field
        run_cfg(254, 255, 1, "R6 max divide");
        run_cfg(4, 255, 1, "R6 p4 r255");

        // R9: a change in the middle of a high half waits for the period end
        run_cfg(4, 3, 0, "R9 setup");
        repeat (3) @(negedge clk);
        presc = 8'd6;
        rate = 8'd1;
        wait_level(1'b0, n);
        check(n == 8 - 3, "R9 old high half kept", n, 5);
        wait_level(1'b1, n);
        check(n == 6, "R9 new low half", n, 6);
        wait_level(1'b0, n);
        check(n == 6, "R9 new high half", n, 6);

        // R2: dropping enable returns the outputs to idle and restarts the phase
        run_cfg(4, 2, 0, "R2 setup");
        @(negedge clk);
        en = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(!sclk && !rise_stb && !fall_stb, "R2 idle while disabled", sclk, 0);
        end
        en = 1'b1;
        wait_level(1'b1, n);
        check(n == 6, "R2 restart phase", n, 6);

        // R3: constrained random settings
        for (int t = 0; t < 12; t++) begin
            int p;
            int r;
            p = $urandom % 24;
            r = $urandom % 12;
            run_cfg(p, r, 3, "R3 random");
        end

        en = 1'b0;
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule